// File: doc/BRIEF.md
# Clock-Generator Control Register Slave on a Two-Wire Bus

This block is the control port of an on-chip clock generator. An external system-management master reaches a bank of eight 8-bit control registers over a two-wire serial bus. The block runs on a fast system clock and takes the bus clock and data lines already synchronised to that clock. It pulls the data line low through a single open-drain enable output. The register bank also drives the generator's analog side in parallel: it holds per-output clock enables, the spread-spectrum depth and enable, and test-mode selection.

Every transfer begins with the device address and a command byte. Bit 7 of the command chooses between two modes. In single-byte mode, the low five bits of the command give the register offset. In block mode, the bank is walked upward from offset 0. Block transfers carry a length byte. The master supplies it on writes, and the slave returns a fixed value on reads. A read is addressed by a write phase that holds the command, followed by a repeated START with the read bit set. A START or STOP at any moment abandons the current transfer.

Top module: `clkgen_smb_regs`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read), that is, 7-bit address 0x69 with the R/W flag in bit 0 (0 = write). Any other address is not acknowledged, and SDA stays released until the next START.
- R2: Command bit 7 = 1 selects single-byte mode and bit 7 = 0 selects block mode. Command bits 6:5 must be 00. Otherwise the command byte is not acknowledged, and all later bytes are ignored and not acknowledged until the next START.
- R3: In a single-byte write (address+W, command with offset in bits 4:0, data), the data byte is stored at that offset, and every byte is acknowledged.
- R4: In a single-byte read (address+W, command, repeated START, address+R), the slave returns the register at the command offset, MSB first.
- R5: In a block write, the slave acknowledges the length byte that follows the command, then stores the data bytes at offsets 0, 1, 2 and so on upward, acknowledging each byte.
- R6: A block read returns the length value first (parameter, default 8), then the registers from offset 0 upward. The slave stops driving after the master does not acknowledge a byte, so the master may end after any byte.
- R7: After reset, the registers at offsets 0 to 7 hold 0x7C, 0x00, 0xEB, 0xAF, 0x01, 0x00, 0x13 and 0x38.
- R8: Offset 7 is read-only. Offsets 8 and above read as 0x00, and writes to them are discarded. Block-write bytes past offset 7 are still acknowledged.
- R9: The parallel outputs are decoded from the bank as follows. src_oe[4:0] = reg0[6:2]. ss_deep = reg2[7] (1 = 0.50 % down-spread, 0 = 0.35 %). ss_en = reg2[2]. refn_sel = reg6[7]. test_mode = reg6[6]. bank_q carries register i in bits 8i+7:8i.
- R10: A START or STOP seen mid-transfer discards the byte in progress, releases SDA and returns the slave to address reception.
- R11: A read address (0xD3) is not acknowledged unless a valid command has been accepted since the last STOP or write address.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| sda_oe | output | 1 | 1 = pull SDA low |
| src_oe | output | 5 | Per-output differential clock enables |
| ss_deep | output | 1 | Spread-spectrum depth select |
| ss_en | output | 1 | Spread-spectrum enable |
| refn_sel | output | 1 | Test output: divided reference (1) or tri-state (0) |
| test_mode | output | 1 | Test-mode entry |
| bank_q | output | 64 | Whole register bank, register i in bits 8i+7:8i |

## Verification
A table of single-byte write/read pairs is walked. It covers a writable register, the read-only register and an offset past the bank. Alternating bit patterns such as 0x55 and 0xAA reveal a reversed bit order, and the out-of-range and read-only rows reveal a missing write guard. Block writes and reads follow with ten data bytes. They separate correct upward addressing and the leading length byte from off-by-one pointer errors, and show that bytes past the bank are acknowledged but dropped. Foreign addresses, a bad chip-select field, a read with no command, and a STOP in the middle of a byte each reveal whether the slave stays off the bus and leaves the bank untouched.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CMD,
      PH_COUNT,
      PH_WDATA,
      PH_TX
   } phase_t;
endpackage

// File: rtl/smbreg_cond.sv
module smbreg_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop,
   output logic scl_lvl,
   output logic sda_lvl
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign bus_start = scl_i & scl_q & sda_q & ~sda_i;
   assign bus_stop  = scl_i & scl_q & ~sda_q & sda_i;
   assign scl_lvl   = scl_q;
   assign sda_lvl   = sda_i;
endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank #(
   parameter int                  NREG     = 8,
   parameter int                  AW       = 6,
   parameter logic [8*NREG-1:0]   DEFAULTS = '0,
   parameter logic [NREG-1:0]     RO_MASK  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [7:0]        wdata,
   input  logic [AW-1:0]     raddr,
   output logic [7:0]        rdata,
   output logic [8*NREG-1:0] q
);
   localparam logic [AW-1:0] LAST = AW'(NREG - 1);

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (RO_MASK[i]) begin : g_ro
         assign q[i*8 +: 8] = DEFAULTS[i*8 +: 8];
      end else begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i*8 +: 8] <= DEFAULTS[i*8 +: 8];
            else if (we && waddr == AW'(i))
               q[i*8 +: 8] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < NREG; i++)
         if (raddr == AW'(i)) rdata = q[i*8 +: 8];
   end

   // R8: a write beyond the last register leaves the whole bank unchanged
   a_r8_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr > LAST) |=> (q == $past(q)));
endmodule

// File: rtl/smbreg_ctrl.sv
module smbreg_ctrl
   import smbreg_pkg::*;
#(
   parameter logic [6:0] ADDR7     = 7'h69,
   parameter logic [7:0] BLK_COUNT = 8'd8,
   parameter int         AW        = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          bus_start,
   input  logic          bus_stop,
   input  logic          scl_lvl,
   input  logic          sda_lvl,
   input  logic [7:0]    rdata,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [7:0]    wdata,
   output logic [AW-1:0] raddr,
   output logic          sda_oe
);
   localparam int OFFW = AW - 1;

   phase_t        ph, ph_nxt;
   logic [3:0]    bcnt;
   logic [7:0]    sh;
   logic          cmd_ok, blk;
   logic [AW-1:0] ptr, ptr_inc;

   assign ptr_inc = (&ptr) ? ptr : ptr + 1'b1;
   assign raddr   = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         ph_nxt <= PH_IDLE;
         bcnt   <= '0;
         sh     <= '0;
         cmd_ok <= 1'b0;
         blk    <= 1'b0;
         ptr    <= '0;
         sda_oe <= 1'b0;
         we     <= 1'b0;
         waddr  <= '0;
         wdata  <= '0;
      end else begin
         we <= 1'b0;
         if (bus_start || bus_stop) begin
            ph     <= PH_ADDR;
            bcnt   <= '0;
            sda_oe <= 1'b0;
            if (bus_stop) cmd_ok <= 1'b0;
         end else if (ph == PH_TX) begin
            if (scl_rise) begin
               if (bcnt < 4'd8) bcnt <= bcnt + 1'b1;
               else if (bcnt == 4'd8) begin
                  bcnt <= 4'd9;
                  if (sda_lvl) ph <= PH_IDLE;   // master NACK ends the read
               end
            end else if (scl_fall) begin
               if (bcnt == 4'd8) sda_oe <= 1'b0;
               else if (bcnt == 4'd9) begin
                  sh     <= rdata;
                  sda_oe <= ~rdata[7];
                  ptr    <= ptr_inc;
                  bcnt   <= '0;
               end else if (bcnt != 4'd0) begin
                  sh     <= {sh[6:0], 1'b0};
                  sda_oe <= ~sh[6];
               end
            end
         end else if (ph != PH_IDLE) begin
            if (scl_rise && bcnt < 4'd8) begin
               sh   <= {sh[6:0], sda_lvl};
               bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == 4'd8) begin
               bcnt   <= 4'd9;
               ph_nxt <= PH_IDLE;
               unique case (ph)
                  PH_ADDR: begin
                     if (sh[7:1] == ADDR7 && (!sh[0] || cmd_ok)) begin
                        sda_oe <= 1'b1;
                        ph_nxt <= sh[0] ? PH_TX : PH_CMD;
                        if (!sh[0]) cmd_ok <= 1'b0;
                     end
                  end
                  PH_CMD: begin
                     if (sh[6:5] == 2'b00) begin
                        sda_oe <= 1'b1;
                        cmd_ok <= 1'b1;
                        blk    <= ~sh[7];
                        ptr    <= sh[7] ? {1'b0, sh[OFFW-1:0]} : '0;
                        ph_nxt <= sh[7] ? PH_WDATA : PH_COUNT;
                     end
                  end
                  PH_COUNT: begin
                     sda_oe <= 1'b1;
                     ph_nxt <= PH_WDATA;
                  end
                  PH_WDATA: begin
                     sda_oe <= 1'b1;
                     we     <= 1'b1;
                     waddr  <= ptr;
                     wdata  <= sh;
                     ptr    <= ptr_inc;
                     ph_nxt <= PH_WDATA;
                  end
                  default: ;
               endcase
            end else if (scl_fall && bcnt == 4'd9) begin
               bcnt   <= '0;
               sda_oe <= 1'b0;
               ph     <= ph_nxt;
               if (ph_nxt == PH_TX) begin
                  if (blk) begin
                     sh     <= BLK_COUNT;
                     sda_oe <= ~BLK_COUNT[7];
                  end else begin
                     sh     <= rdata;
                     sda_oe <= ~rdata[7];
                     ptr    <= ptr_inc;
                  end
               end
            end
         end
      end
   end

   // R10: bus condition releases SDA and restarts address reception
   a_r10_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start || bus_stop) |=> (!sda_oe && ph == PH_ADDR));
   // R12: slave begins pulling SDA only during SCL low
   a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl);
   // R1: while waiting for a START the slave never drives
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) |-> !sda_oe);
   // R8: write strobes only follow an acknowledged data byte
   a_r8_write_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> sda_oe);
endmodule

// File: rtl/clkgen_smb_regs.sv
module clkgen_smb_regs #(
   parameter logic [6:0]        ADDR7     = 7'h69,
   parameter logic [7:0]        BLK_COUNT = 8'd8,
   parameter int                NREG      = 8,
   parameter logic [8*NREG-1:0] DEFAULTS  = 64'h3813_0001_AFEB_007C,
   parameter logic [NREG-1:0]   RO_MASK   = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [4:0]        src_oe,
   output logic              ss_deep,
   output logic              ss_en,
   output logic              refn_sel,
   output logic              test_mode,
   output logic [8*NREG-1:0] bank_q
);
   localparam int OFFW    = 5;
   localparam int AW      = OFFW + 1;
   localparam int IDX_OE  = 0;
   localparam int IDX_SS  = 2;
   localparam int IDX_TST = 6;

   if (NREG < IDX_TST + 1 || NREG > (1 << OFFW)) begin : g_bad_nreg
      $error("NREG must cover the control registers and fit the offset field");
   end

   logic scl_rise, scl_fall, bus_start, bus_stop, scl_lvl, sda_lvl;
   logic we;
   logic [AW-1:0] waddr, raddr;
   logic [7:0] wdata, rdata;

   smbreg_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
   );

   smbreg_ctrl #(.ADDR7(ADDR7), .BLK_COUNT(BLK_COUNT), .AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .rdata(rdata), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .sda_oe(sda_oe)
   );

   smbreg_bank #(.NREG(NREG), .AW(AW), .DEFAULTS(DEFAULTS), .RO_MASK(RO_MASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata), .q(bank_q)
   );

   assign src_oe    = bank_q[IDX_OE*8 + 2 +: 5];
   assign ss_deep   = bank_q[IDX_SS*8 + 7];
   assign ss_en     = bank_q[IDX_SS*8 + 2];
   assign refn_sel  = bank_q[IDX_TST*8 + 7];
   assign test_mode = bank_q[IDX_TST*8 + 6];
endmodule

// File: tb/sim_clkgen_smb_regs.sv
module sim_clkgen_smb_regs;
   localparam int H = 6;
   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_line;
   logic sda_oe, ss_deep, ss_en, refn_sel, test_mode;
   logic [4:0] src_oe;
   logic [63:0] bank_q;
   int checks = 0, errors = 0, r12_viol = 0;
   bit done = 0;

   always #2.5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   clkgen_smb_regs u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .src_oe(src_oe), .ss_deep(ss_deep), .ss_en(ss_en),
      .refn_sel(refn_sel), .test_mode(test_mode), .bank_q(bank_q)
   );

   // R12 monitor: drive changes seen while SCL stayed high
   logic oe_prev = 1'b0, scl_prev = 1'b1;
   always @(negedge clk) begin
      if (rst_n && scl_m && scl_prev && sda_oe != oe_prev) r12_viol++;
      oe_prev  <= sda_oe;
      scl_prev <= scl_m;
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic hw();
      repeat (H) @(negedge clk);
   endtask

   task automatic b_start();
      sda_m = 1; scl_m = 1; hw(); sda_m = 0; hw(); scl_m = 0; hw();
   endtask
   task automatic b_rstart();
      sda_m = 1; hw(); scl_m = 1; hw(); sda_m = 0; hw(); scl_m = 0; hw();
   endtask
   task automatic b_stop();
      sda_m = 0; hw(); scl_m = 1; hw(); sda_m = 1; hw();
   endtask
   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; hw(); scl_m = 1; hw(); scl_m = 0; hw();
      end
   endtask
   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      sda_m = 1; hw(); scl_m = 1; hw(); ack = ~sda_line; scl_m = 0; hw();
   endtask
   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      sda_m = 1;
      for (int i = 0; i < 8; i++) begin
         hw(); scl_m = 1; hw(); b = {b[6:0], sda_line}; scl_m = 0;
      end
      hw(); sda_m = ~give_ack; hw(); scl_m = 1; hw(); scl_m = 0; hw(); sda_m = 1;
   endtask

   task automatic byte_write(input logic [7:0] cmd, input logic [7:0] d, output logic [2:0] acks);
      b_start();
      send_byte(8'hD2, acks[2]); send_byte(cmd, acks[1]); send_byte(d, acks[0]);
      b_stop();
   endtask
   task automatic byte_read(input logic [7:0] cmd, output logic [2:0] acks, output logic [7:0] d);
      b_start();
      send_byte(8'hD2, acks[2]); send_byte(cmd, acks[1]);
      b_rstart(); send_byte(8'hD3, acks[0]);
      recv_byte(1'b0, d);
      b_stop();
   endtask

   // {command, data written, value expected on read-back}
   localparam logic [23:0] VEC [6] = '{
      24'h80_55_55, 24'h82_00_00, 24'h86_C0_C0,
      24'h87_FF_38, 24'h8A_AA_00, 24'h83_AA_AA
   };

   function automatic logic [7:0] bdat(input int i);
      return 8'h1F + 8'(i) * 8'h23;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [2:0] a3;
      logic a;
      logic [7:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1;
      hw();
      // reset state
      check("R7 reset bank", bank_q, 64'h3813_0001_AFEB_007C);
      check("R9 reset outputs", {59'd0, src_oe}, 64'h1F);
      check("R9 reset ss/test", {60'd0, ss_deep, ss_en, refn_sel, test_mode}, 64'h8);
      check("R1 reset sda released", {63'd0, sda_oe}, 64'd0);

      // R6/R7 block read of defaults
      b_start(); send_byte(8'hD2, a3[2]); send_byte(8'h00, a3[1]);
      b_rstart(); send_byte(8'hD3, a3[0]);
      check("R6 block read acks", {61'd0, a3}, 64'h7);
      recv_byte(1'b1, d);
      check("R6 length byte", {56'd0, d}, 64'd8);
      for (int i = 0; i < 8; i++) begin
         recv_byte(i != 7, d);
         check("R7 default via block read", {56'd0, d}, {56'd0, 64'h3813_0001_AFEB_007C >> (8*i)} & 64'hFF);
      end
      b_stop();

      // table walk: single-byte write then read (R3, R4, R8)
      for (int k = 0; k < 6; k++) begin
         byte_write(VEC[k][23:16], VEC[k][15:8], a3);
         check("R3 byte write acks", {61'd0, a3}, 64'h7);
         byte_read(VEC[k][23:16], a3, d);
         check("R4 byte read acks", {61'd0, a3}, 64'h7);
         check("R4/R8 read-back", {56'd0, d}, {56'd0, VEC[k][7:0]});
      end
      check("R9 src_oe after writes", {59'd0, src_oe}, 64'h15);
      check("R9 ss/test after writes", {60'd0, ss_deep, ss_en, refn_sel, test_mode}, 64'h3);

      // R1 foreign address
      b_start(); send_byte(8'hA4, a); b_stop();
      check("R1 foreign address nack", {63'd0, a}, 64'd0);

      // R2 chip-select mismatch
      b_start(); send_byte(8'hD2, a3[2]); send_byte(8'hA1, a3[1]); send_byte(8'h5A, a3[0]); b_stop();
      check("R2 cs mismatch acks", {61'd0, a3}, 64'h4);
      byte_read(8'h81, a3, d);
      check("R2 reg1 untouched", {56'd0, d}, 64'h00);

      // R5/R8 block write of ten bytes
      b_start(); send_byte(8'hD2, a3[2]); send_byte(8'h00, a3[1]); send_byte(8'd10, a3[0]);
      check("R5 addr/cmd/length acks", {61'd0, a3}, 64'h7);
      for (int i = 0; i < 10; i++) begin
         send_byte(bdat(i), a);
         check("R5/R8 data ack", {63'd0, a}, 64'd1);
      end
      b_stop();
      b_start(); send_byte(8'hD2, a); send_byte(8'h00, a); b_rstart(); send_byte(8'hD3, a);
      recv_byte(1'b1, d);
      check("R6 length after write", {56'd0, d}, 64'd8);
      for (int i = 0; i < 8; i++) begin
         recv_byte(i != 7, d);
         check("R5/R8 block read-back", {56'd0, d}, {56'd0, (i == 7) ? 8'h38 : bdat(i)});
      end
      b_stop();

      // R6 early end: NACK after the first register
      b_start(); send_byte(8'hD2, a); send_byte(8'h00, a); b_rstart(); send_byte(8'hD3, a);
      recv_byte(1'b1, d); recv_byte(1'b0, d);
      check("R6 early end data", {56'd0, d}, {56'd0, bdat(0)});
      check("R6 released after nack", {63'd0, sda_oe}, 64'd0);
      b_stop();
      byte_read(8'h82, a3, d);
      check("R6 next transfer after early end", {53'd0, a3, d}, {53'd0, 3'b111, bdat(2)});

      // R10 STOP in the middle of a data byte
      b_start(); send_byte(8'hD2, a); send_byte(8'h81, a); send_bits(8'h00, 3);
      scl_m = 0; b_stop();
      byte_read(8'h81, a3, d);
      check("R10 aborted byte not stored", {53'd0, a3, d}, {53'd0, 3'b111, bdat(1)});

      // R11 read address without a command
      b_start(); send_byte(8'hD3, a); b_stop();
      check("R11 read without command nack", {63'd0, a}, 64'd0);

      check("R12 drive changes only while SCL low", 64'(r12_viol), 64'd0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule